// File: doc/BRIEF.md
# I2C Master SCL Period Generator

This block produces the serial clock of an I2C master from programmable phase counts, running on the controller clock. Two pairs of high/low counts are held, one for standard speed and one for fast speed, and a mode field in a control word picks the pair. A programmable spike-filter length stretches each high phase. An SDA hold count tells the data path how many controller clocks after each falling SCL edge it must wait before it may change SDA. The effective SDA hold window comes from this count, or from a built-in default when the count is zero.

Software loads the timing words through a small write port while the block is disabled. Raising `enable` snapshots them into working registers. While `run_req` is high the block emits back-to-back periods, each a low phase followed by a high phase. When `run_req` drops, SCL stays high after the current high phase. Dropping `enable` lets the phase in progress finish, then parks SCL high and clears `enable_status`.

Top module: `i2c_scl_timer`

## Requirements
- R1: Each SCL low phase lasts exactly max(LO,8)+1 controller clock cycles, where LO is the selected low count.
- R2: Each SCL high phase between two low phases lasts exactly max(HI,6)+SPIKE+7 cycles, where HI is the selected high count.
- R3: Write address 0 is the control word, and its bits [1:0] select the speed pair. A value of 1 selects standard (addresses 1 = high, 2 = low) and 2 selects fast (addresses 3 = high, 4 = low). Values 0 and 3 leave the previous selection unchanged. Reset selects standard.
- R4: The spike length (address 5, bits [7:0]) adds cycle for cycle to the high phase.
- R5: High counts below 6 act as 6 and low counts below 8 act as 8.
- R6: The SDA hold count is written at address 6. During a low phase, `sda_change_ok` is 0 for the first H cycles and 1 for the rest of that phase, where H is the hold count, or 4 when the hold count is 0. While SCL is high, `sda_change_ok` is 0.
- R7: All timing words are captured only when `enable` rises. Writes made while enabled have no effect until the next enable.
- R8: `enable_status` is 1 on the cycle after `enable` rises. After `enable` drops, the phase in progress completes at full length, and `enable_status` reads 0 once SCL is back high.
- R9: After reset, `scl_out` is 1, `sda_change_ok` is 0 and `enable_status` is 0.
- R10: When `run_req` is low at the end of a high phase, SCL stays high and no further period starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Timing word write strobe |
| wr_addr | input | 3 | Timing word address |
| wr_data | input | 16 | Timing word value |
| enable | input | 1 | Enable request; rising edge captures settings |
| run_req | input | 1 | Keep generating SCL periods while high |
| scl_out | output | 1 | Serial clock level |
| sda_change_ok | output | 1 | SDA may change now (hold window passed) |
| enable_status | output | 1 | Block is actually running |

## Verification
A bad phase counter or a wrong pair selection shows up on the very next SCL edge as a phase one or more cycles off. The scoreboard compares every low and every inner high run against the expected lengths. A stuck hold counter shows up within the first low phase as `sda_change_ok` rising at the wrong index. A bad activity flag shows up as `enable_status` disagreeing with SCL on the cycle that a draining phase ends. A snapshot taken at the wrong time shows up as the first period after a write while enabled using the new values.

// File: rtl/i2c_scl_pkg.sv
package i2c_scl_pkg;
   typedef enum logic [1:0] {PH_IDLE = 2'd0, PH_LOW = 2'd1, PH_HIGH = 2'd2} scl_phase_e;

   localparam logic [2:0] A_CTRL   = 3'd0;
   localparam logic [2:0] A_STD_HI = 3'd1;
   localparam logic [2:0] A_STD_LO = 3'd2;
   localparam logic [2:0] A_FST_HI = 3'd3;
   localparam logic [2:0] A_FST_LO = 3'd4;
   localparam logic [2:0] A_SPIKE  = 3'd5;
   localparam logic [2:0] A_HOLD   = 3'd6;

   localparam logic [1:0] MODE_STD  = 2'd1;
   localparam logic [1:0] MODE_FAST = 2'd2;
endpackage

// File: rtl/scl_cfg_regs.sv
module scl_cfg_regs
   import i2c_scl_pkg::*;
#(
   parameter int CW = 16,
   parameter int SW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [2:0]    wr_addr,
   input  logic [CW-1:0] wr_data,
   output logic [CW-1:0] std_hi,
   output logic [CW-1:0] std_lo,
   output logic [CW-1:0] fst_hi,
   output logic [CW-1:0] fst_lo,
   output logic [SW-1:0] spike,
   output logic [CW-1:0] hold,
   output logic          fast_sel
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         std_hi   <= '0;
         std_lo   <= '0;
         fst_hi   <= '0;
         fst_lo   <= '0;
         spike    <= '0;
         hold     <= '0;
         fast_sel <= 1'b0;
      end else if (wr_en) begin
         case (wr_addr)
            A_CTRL: begin
               if (wr_data[1:0] == MODE_STD)       fast_sel <= 1'b0;
               else if (wr_data[1:0] == MODE_FAST) fast_sel <= 1'b1;
            end
            A_STD_HI: std_hi <= wr_data;
            A_STD_LO: std_lo <= wr_data;
            A_FST_HI: fst_hi <= wr_data;
            A_FST_LO: fst_lo <= wr_data;
            A_SPIKE:  spike  <= wr_data[SW-1:0];
            A_HOLD:   hold   <= wr_data;
            default: ;
         endcase
      end
   end

   AST_MODE_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == A_CTRL && wr_data[1:0] != MODE_STD && wr_data[1:0] != MODE_FAST)
      |=> $stable(fast_sel)); // R3
   AST_MODE_FAST: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == A_CTRL && wr_data[1:0] == MODE_FAST) |=> fast_sel); // R3
endmodule

// File: rtl/scl_phase_calc.sv
module scl_phase_calc #(
   parameter int CW       = 16,
   parameter int SW       = 8,
   parameter int PW       = 18,
   parameter int MIN_HI   = 6,
   parameter int MIN_LO   = 8,
   parameter int DEF_HOLD = 4
) (
   input  logic          fast_sel,
   input  logic [CW-1:0] std_hi,
   input  logic [CW-1:0] std_lo,
   input  logic [CW-1:0] fst_hi,
   input  logic [CW-1:0] fst_lo,
   input  logic [SW-1:0] spike,
   input  logic [CW-1:0] hold,
   output logic [PW-1:0] hi_len,
   output logic [PW-1:0] lo_len,
   output logic [CW-1:0] hold_len
);
   localparam logic [CW-1:0] MIN_HI_C  = CW'(MIN_HI);
   localparam logic [CW-1:0] MIN_LO_C  = CW'(MIN_LO);
   localparam logic [CW-1:0] DEF_HLD_C = CW'(DEF_HOLD);
   localparam logic [PW-1:0] HI_FIXED  = PW'(7);

   logic [CW-1:0] sel_hi, sel_lo, cl_hi, cl_lo;

   assign sel_hi = fast_sel ? fst_hi : std_hi;
   assign sel_lo = fast_sel ? fst_lo : std_lo;

   generate
      if (MIN_HI > 0) begin : g_hi_clamp
         assign cl_hi = (sel_hi < MIN_HI_C) ? MIN_HI_C : sel_hi;
      end else begin : g_hi_raw
         assign cl_hi = sel_hi;
      end
      if (MIN_LO > 0) begin : g_lo_clamp
         assign cl_lo = (sel_lo < MIN_LO_C) ? MIN_LO_C : sel_lo;
      end else begin : g_lo_raw
         assign cl_lo = sel_lo;
      end
   endgenerate

   assign hi_len   = PW'(cl_hi) + PW'(spike) + HI_FIXED;
   assign lo_len   = PW'(cl_lo) + PW'(1);
   assign hold_len = (hold == '0) ? DEF_HLD_C : hold;
endmodule

// File: rtl/scl_hold_gen.sv
module scl_hold_gen #(
   parameter int CW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          in_low,
   input  logic [CW-1:0] hold_len,
   output logic          sda_ok
);
   logic [CW-1:0] lcnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              lcnt_q <= '0;
      else if (!in_low)        lcnt_q <= '0;
      else if (lcnt_q != '1)   lcnt_q <= lcnt_q + 1'b1;
   end

   assign sda_ok = in_low && (lcnt_q >= hold_len);

   AST_CNT_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !in_low |=> (lcnt_q == '0)); // R6
endmodule

// File: rtl/scl_phase_fsm.sv
module scl_phase_fsm
   import i2c_scl_pkg::*;
#(
   parameter int CW = 16,
   parameter int PW = 18
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          enable,
   input  logic          run_req,
   input  logic [PW-1:0] hi_len,
   input  logic [PW-1:0] lo_len,
   input  logic [CW-1:0] hold_len,
   output logic          in_low,
   output logic          active,
   output logic [CW-1:0] w_hold
);
   scl_phase_e    state_q, state_n;
   logic [PW-1:0] cnt_q, cnt_n, w_hi, w_lo;
   logic          act_q, act_n, en_q, load, cnt_zero;

   assign load     = enable && !en_q && !act_q;
   assign cnt_zero = (cnt_q == '0);

   always_comb begin
      state_n = state_q;
      cnt_n   = cnt_q;
      act_n   = act_q;
      if (load) act_n = 1'b1;
      case (state_q)
         PH_IDLE: begin
            if (!enable) act_n = 1'b0;
            else if (act_q && run_req) begin
               state_n = PH_LOW;
               cnt_n   = w_lo - 1'b1;
            end
         end
         PH_LOW: begin
            if (!cnt_zero) cnt_n = cnt_q - 1'b1;
            else if (enable) begin
               state_n = PH_HIGH;
               cnt_n   = w_hi - 1'b1;
            end else begin
               state_n = PH_IDLE;
               cnt_n   = '0;
               act_n   = 1'b0;
            end
         end
         PH_HIGH: begin
            if (!cnt_zero) cnt_n = cnt_q - 1'b1;
            else if (enable && run_req) begin
               state_n = PH_LOW;
               cnt_n   = w_lo - 1'b1;
            end else begin
               state_n = PH_IDLE;
               cnt_n   = '0;
               if (!enable) act_n = 1'b0;
            end
         end
         default: begin
            state_n = PH_IDLE;
            cnt_n   = '0;
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= PH_IDLE;
         cnt_q   <= '0;
         act_q   <= 1'b0;
         en_q    <= 1'b0;
         w_hi    <= '0;
         w_lo    <= '0;
         w_hold  <= '0;
      end else begin
         state_q <= state_n;
         cnt_q   <= cnt_n;
         act_q   <= act_n;
         en_q    <= enable;
         if (load) begin
            w_hi   <= hi_len;
            w_lo   <= lo_len;
            w_hold <= hold_len;
         end
      end
   end

   assign in_low = (state_q == PH_LOW);
   assign active = act_q;

   AST_LOW_NEEDS_ACT: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q != PH_IDLE) |-> act_q); // R8
   AST_STATUS_SET: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(act_q) |-> $past(enable)); // R8
   AST_CLEAR_AT_REST: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(act_q) |-> (state_q == PH_IDLE)); // R8
   AST_LOW_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == PH_LOW) |-> (cnt_q < w_lo)); // R1
   AST_HIGH_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == PH_HIGH) |-> (cnt_q < w_hi)); // R2
   AST_RUN_STOP: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == PH_HIGH && cnt_zero && !run_req) |=> (state_q == PH_IDLE)); // R10
endmodule

// File: rtl/i2c_scl_timer.sv
module i2c_scl_timer #(
   parameter int CW       = 16,
   parameter int SW       = 8,
   parameter int MIN_HI   = 6,
   parameter int MIN_LO   = 8,
   parameter int DEF_HOLD = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [2:0]    wr_addr,
   input  logic [CW-1:0] wr_data,
   input  logic          enable,
   input  logic          run_req,
   output logic          scl_out,
   output logic          sda_change_ok,
   output logic          enable_status
);
   localparam int PW = CW + 2;

   initial begin : p_param_chk
      assert (CW >= 8 && SW >= 1 && SW <= CW && DEF_HOLD > 0 && MIN_HI >= 0 && MIN_LO >= 0)
         else $error("i2c_scl_timer: illegal parameter set");
   end

   logic [CW-1:0] std_hi, std_lo, fst_hi, fst_lo, hold, hold_len, w_hold;
   logic [SW-1:0] spike;
   logic [PW-1:0] hi_len, lo_len;
   logic          fast_sel, in_low, sda_ok, active;

   scl_cfg_regs #(.CW(CW), .SW(SW)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .std_hi(std_hi), .std_lo(std_lo), .fst_hi(fst_hi), .fst_lo(fst_lo),
      .spike(spike), .hold(hold), .fast_sel(fast_sel));

   scl_phase_calc #(.CW(CW), .SW(SW), .PW(PW), .MIN_HI(MIN_HI), .MIN_LO(MIN_LO),
                    .DEF_HOLD(DEF_HOLD)) u_calc (
      .fast_sel(fast_sel), .std_hi(std_hi), .std_lo(std_lo), .fst_hi(fst_hi),
      .fst_lo(fst_lo), .spike(spike), .hold(hold),
      .hi_len(hi_len), .lo_len(lo_len), .hold_len(hold_len));

   scl_phase_fsm #(.CW(CW), .PW(PW)) u_fsm (
      .clk(clk), .rst_n(rst_n), .enable(enable), .run_req(run_req),
      .hi_len(hi_len), .lo_len(lo_len), .hold_len(hold_len),
      .in_low(in_low), .active(active), .w_hold(w_hold));

   scl_hold_gen #(.CW(CW)) u_hold (
      .clk(clk), .rst_n(rst_n), .in_low(in_low), .hold_len(w_hold), .sda_ok(sda_ok));

   assign scl_out       = !in_low;
   assign sda_change_ok = sda_ok;
   assign enable_status = active;

   AST_SDA_ONLY_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      sda_change_ok |-> !scl_out); // R6
   AST_HI_WORKING_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
      enable_status |-> (hi_len >= PW'(MIN_HI + 7))); // R5
endmodule

// File: tb/sim_i2c_scl_timer.sv
module sim_i2c_scl_timer;
   localparam int CLK_PERIOD = 10;

   typedef struct {
      bit    lo;
      int    len;
      string tag;
   } exp_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [2:0]  wr_addr = '0;
   logic [15:0] wr_data = '0;
   logic        enable = 1'b0;
   logic        run_req = 1'b0;
   logic        scl_out, sda_change_ok, enable_status;

   int   n_checks = 0;
   int   n_fail   = 0;
   exp_t q[$];
   int   hold_exp = 4;
   int   fall_cnt = 0;
   bit   cur_lvl = 1'b1;
   int   run_len = 0;
   bit   clean = 1'b0;
   bit   sda_bad = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   i2c_scl_timer u0 (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .enable(enable), .run_req(run_req), .scl_out(scl_out),
      .sda_change_ok(sda_change_ok), .enable_status(enable_status));

   task automatic check(bit ok, string tag, int act, int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic int lo_exp(int l);
      return ((l < 8) ? 8 : l) + 1;
   endfunction
   function automatic int hi_exp(int h, int s);
      return ((h < 6) ? 6 : h) + s + 7;
   endfunction

   task automatic finish_run(bit lvl, int len);
      exp_t e;
      if (lvl == 1'b1 && !clean) return;
      if (q.size() == 0) begin
         check(1'b0, "unexpected SCL run", len, 0);
         return;
      end
      e = q.pop_front();
      check(e.lo == !lvl && e.len == len, e.tag, len, e.len);
      if (!lvl) check(!sda_bad, "R6 sda_change_ok window", 0, hold_exp);
   endtask

   // monitor: measures SCL runs and compares with the scoreboard queue
   initial begin
      forever begin
         @(negedge clk);
         if (rst_n) begin
            if (scl_out == cur_lvl) run_len++;
            else begin
               finish_run(cur_lvl, run_len);
               cur_lvl = scl_out;
               run_len = 1;
               clean   = 1'b1;
               if (!scl_out) begin
                  fall_cnt++;
                  sda_bad = 1'b0;
               end
            end
            if (!enable_status) clean = 1'b0;
            if (!scl_out && (sda_change_ok != ((run_len - 1) >= hold_exp))) sda_bad = 1'b1;
         end
      end
   end

   task automatic wr(logic [2:0] a, int d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = 16'(d);
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic turn_on();
      @(negedge clk);
      enable = 1'b1;
      @(negedge clk);
      check(enable_status == 1'b1, "R8 status after enable", enable_status, 1);
   endtask

   task automatic turn_off();
      @(negedge clk);
      enable = 1'b0;
      while (enable_status) @(negedge clk);
   endtask

   // driver: pushes expected runs, then requests n periods
   task automatic burst(int n, int lo, int hi, string tl, string th);
      int start;
      int still;
      for (int i = 0; i < n; i++) begin
         q.push_back('{1'b1, lo, tl});
         if (i < n - 1) q.push_back('{1'b0, hi, th});
      end
      start = fall_cnt;
      @(negedge clk);
      run_req = 1'b1;
      do @(posedge clk); while (fall_cnt < start + n);
      @(negedge clk);
      run_req = 1'b0;
      while (!scl_out) @(negedge clk);
      still = 0;
      for (int i = 0; i < hi + 30; i++) begin
         @(negedge clk);
         if (scl_out) still++;
      end
      check(still == hi + 30, "R10 SCL parked high", still, hi + 30);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check(scl_out == 1'b1, "R9 scl_out in reset", scl_out, 1);
      check(sda_change_ok == 1'b0, "R9 sda_change_ok in reset", sda_change_ok, 0);
      check(enable_status == 1'b0, "R9 enable_status in reset", enable_status, 0);
      @(negedge clk);
      rst_n = 1'b1;

      // R1 R2 standard pair, hold 3
      wr(3'd1, 10); wr(3'd2, 12); wr(3'd5, 0); wr(3'd6, 3); hold_exp = 3;
      turn_on();
      burst(3, lo_exp(12), hi_exp(10, 0), "R1 std low", "R2 std high");
      turn_off();

      // R4 spike length
      wr(3'd5, 5);
      turn_on();
      burst(3, lo_exp(12), hi_exp(10, 5), "R1 low", "R4 spike high");
      turn_off();

      // R5 clamping
      wr(3'd1, 2); wr(3'd2, 3);
      turn_on();
      burst(2, lo_exp(3), hi_exp(2, 5), "R5 low clamp", "R5 high clamp");
      turn_off();

      // R3 fast pair
      wr(3'd3, 20); wr(3'd4, 25); wr(3'd0, 2);
      turn_on();
      burst(2, lo_exp(25), hi_exp(20, 5), "R3 fast low", "R3 fast high");
      turn_off();

      // R3 values 3 and 0 keep fast
      wr(3'd0, 3); wr(3'd0, 0);
      turn_on();
      burst(2, lo_exp(25), hi_exp(20, 5), "R3 keep low", "R3 keep high");
      turn_off();

      // R3 back to standard
      wr(3'd0, 1);
      turn_on();
      burst(2, lo_exp(3), hi_exp(2, 5), "R3 std low", "R3 std high");
      turn_off();

      // R6 default hold
      wr(3'd1, 10); wr(3'd2, 12); wr(3'd5, 0); wr(3'd6, 0); hold_exp = 4;
      turn_on();
      burst(2, lo_exp(12), hi_exp(10, 0), "R6 low", "R6 high");
      turn_off();

      // R6 hold longer than the low phase
      wr(3'd6, 20); hold_exp = 20;
      turn_on();
      burst(2, lo_exp(12), hi_exp(10, 0), "R6 long hold low", "R6 long hold high");
      turn_off();

      // R7 writes while enabled are ignored until next enable
      wr(3'd6, 3); hold_exp = 3;
      turn_on();
      wr(3'd1, 30); wr(3'd2, 40); wr(3'd5, 2); wr(3'd6, 9);
      burst(2, lo_exp(12), hi_exp(10, 0), "R7 old low", "R7 old high");
      turn_off();
      hold_exp = 9;
      turn_on();
      burst(2, lo_exp(40), hi_exp(30, 2), "R7 new low", "R7 new high");
      turn_off();

      // R8 disable in the middle of a low phase
      begin
         int start;
         bit st_bad;
         turn_on();
         q.push_back('{1'b1, lo_exp(40), "R8 drained low"});
         start = fall_cnt;
         @(negedge clk);
         run_req = 1'b1;
         do @(posedge clk); while (fall_cnt < start + 1);
         @(negedge clk);
         enable = 1'b0;
         run_req = 1'b0;
         st_bad = 1'b0;
         while (!scl_out) begin
            if (!enable_status) st_bad = 1'b1;
            @(negedge clk);
         end
         check(!st_bad, "R8 status held while draining", 0, 1);
         check(enable_status == 1'b0, "R8 status cleared at rest", enable_status, 0);
      end

      repeat (20) @(negedge clk);
      check(q.size() == 0, "scoreboard drained", q.size(), 0);
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
   end
endmodule